// File: doc/BRIEF.md
# Streaming Matrix-Vector Multiply-Accumulate Engine

This engine forms the product of a matrix and a vector in 16-bit signed fixed-point, as one step of a decoding pipeline. The vector is first written into an internal operand FIFO through a valid/ready stream. Matrix elements then arrive on a second stream in row-major order. Each arriving element is multiplied by the element at the FIFO head and added into a wide accumulator. At the end of a row, the sum is rescaled and saturated, and the result leaves on a third stream. Every element read from the FIFO is written back into it, so the same vector serves every row without being sent again. On the final row the FIFO is left to drain.

Two options let chained products run with no processor step between them. With reuse enabled, the results of one operation are copied into the operand FIFO after its last row, and the next operation starts on them. With accumulate-previous enabled, each row starts from the result the same row produced in the preceding operation, so two products can be summed. The rescaling shift is set separately for each output position through a small write port. The vector length and the row count are plain configuration inputs, and they must be held steady while `busy` is high.

Top module: `mvmac_stream`

## Requirements
- R1: While idle, `vec_ready` is high exactly when the FIFO holds fewer than `cfg_row_len` elements. An operation begins on its own in the cycle after the FIFO holds `cfg_row_len` elements, where `cfg_row_len` is from 1 to 128. `vec_ready` and `mat_ready` are never high together.
- R2: Output element r equals sat16((sum over j of M[r][j]*v[j]) >>> f[r]). The products are signed 16x16, the sum is kept in 40 bits, and f[r] is the shift stored for position r.
- R3: During an operation the vector is read once per row from the FIFO and recirculated. `vec_ready` stays low from the start of the operation until `busy` falls, and no element is lost or duplicated.
- R4: Results leave in row order. `res_valid` rises in the cycle after the last element of a row is accepted. While `res_valid` is high and `res_ready` is low, `res_data` holds steady and `mat_ready` stays low.
- R5: Results above 32767 become 32767, and results below -32768 become -32768.
- R6: The shift f[r] (0 to 15) is written with `frac_we`, `frac_addr` = r and `frac_val`. The shift is arithmetic, so negative sums round toward minus infinity.
- R7: With `cfg_reuse` set, the engine copies the row_cnt results into the FIFO as the next vector, one per cycle, after the last matrix element. During this copy `mat_ready` and `vec_ready` stay low. If `cfg_row_len` then equals the previous row count, the next operation starts with no vector transfer.
- R8: With `cfg_acc_prev` set, output r equals sat16(p[r] + (S[r] >>> f[r])). Here S[r] is the row sum and p[r] is the value output at position r by the previous operation.
- R9: `busy` is high from the cycle after the operation starts until it ends. `done` is a one-cycle pulse that is high in the first cycle `busy` reads low. Without reuse this is the cycle after the last matrix element is accepted. With reuse it comes row_cnt cycles later.
- R10: After reset `busy`, `done`, `res_valid` and `mat_ready` are low, and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_row_len | input | 8 | Vector length / row length (1..128) |
| cfg_row_cnt | input | 5 | Number of matrix rows (1..16) |
| cfg_reuse | input | 1 | Copy results into the FIFO as the next vector |
| cfg_acc_prev | input | 1 | Start each row from the previous result of that row |
| frac_we | input | 1 | Write strobe for the per-position shift table |
| frac_addr | input | 4 | Output position written |
| frac_val | input | 4 | Right shift applied to that position |
| vec_valid | input | 1 | Vector element valid |
| vec_ready | output | 1 | Vector element accepted |
| vec_data | input | 16 | Vector element, signed |
| mat_valid | input | 1 | Matrix element valid |
| mat_ready | output | 1 | Matrix element accepted |
| mat_data | input | 16 | Matrix element, signed, row-major |
| res_valid | output | 1 | Result element valid |
| res_ready | input | 1 | Result element taken |
| res_data | output | 16 | Result element, signed, saturated |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
Three kinds of result have fixed timing. The accepting edge of a row's last matrix element registers that row's result, so the bench reads `res_valid` and `res_data` at the falling edge straight after that acceptance. `done` is due in the same cycle without reuse and exactly row_cnt cycles later with reuse, and the bench compares the cycle numbers it records. A chained start shows up one cycle after the configuration change. The bench drives and samples only on falling edges, so every read falls between two registering edges.

// File: rtl/mvmac_pkg.sv
package mvmac_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_REFILL = 2'd2
  } mv_state_e;

endpackage

// File: rtl/mvmac_fifo.sv
module mvmac_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 128
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push,
  input  logic [W-1:0]           push_data,
  input  logic                   pop,
  output logic [W-1:0]           head,
  output logic [$clog2(DEPTH):0] count
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wr_nx, rd_nx;
  logic [AW:0]   cnt_nx;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_nx  = push ? bump(wr_ptr) : wr_ptr;
    rd_nx  = pop  ? bump(rd_ptr) : rd_ptr;
    cnt_nx = count + (AW+1)'(push) - (AW+1)'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_nx;
      rd_ptr <= rd_nx;
      count  <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  assign head = mem[rd_ptr];

  // R3
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (count < (AW+1)'(DEPTH)));

  // R3
  fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));

endmodule

// File: rtl/mvmac_acc.sv
module mvmac_acc #(
  parameter int DW     = 16,
  parameter int ACC_W  = 40,
  parameter int FRAC_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    first,
  input  logic signed [DW-1:0]    a,
  input  logic signed [DW-1:0]    b,
  input  logic signed [ACC_W-1:0] init,
  input  logic [FRAC_W-1:0]       frac,
  output logic signed [DW-1:0]    sat_out
);
  localparam logic signed [ACC_W-1:0] HI = ACC_W'((64'sd1 <<< (DW-1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] LO = -HI - ACC_W'(1);

  logic signed [2*DW-1:0]  prod;
  logic signed [ACC_W-1:0] prod_ext, base, acc_q, acc_nx, shifted;

  always_comb begin
    prod     = a * b;
    prod_ext = {{(ACC_W-2*DW){prod[2*DW-1]}}, prod};
    base     = first ? init : acc_q;
    acc_nx   = base + prod_ext;
    shifted  = acc_nx >>> frac;
    if (shifted > HI)      sat_out = HI[DW-1:0];
    else if (shifted < LO) sat_out = LO[DW-1:0];
    else                   sat_out = shifted[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= acc_nx;
  end

endmodule

// File: rtl/mvmac_stream.sv
module mvmac_stream
  import mvmac_pkg::*;
#(
  parameter int DW       = 16,
  parameter int DEPTH    = 128,
  parameter int MAX_ROWS = 16,
  parameter int ACC_W    = 40,
  parameter int FRAC_W   = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [$clog2(DEPTH):0]          cfg_row_len,
  input  logic [$clog2(MAX_ROWS):0]       cfg_row_cnt,
  input  logic                            cfg_reuse,
  input  logic                            cfg_acc_prev,
  input  logic                            frac_we,
  input  logic [$clog2(MAX_ROWS)-1:0]     frac_addr,
  input  logic [FRAC_W-1:0]               frac_val,
  input  logic                            vec_valid,
  output logic                            vec_ready,
  input  logic signed [DW-1:0]            vec_data,
  input  logic                            mat_valid,
  output logic                            mat_ready,
  input  logic signed [DW-1:0]            mat_data,
  output logic                            res_valid,
  input  logic                            res_ready,
  output logic signed [DW-1:0]            res_data,
  output logic                            busy,
  output logic                            done
);
  localparam int LEN_W  = $clog2(DEPTH) + 1;
  localparam int ROW_W  = $clog2(MAX_ROWS) + 1;
  localparam int RIDX_W = $clog2(MAX_ROWS);
  localparam int CIDX_W = $clog2(DEPTH);

  mv_state_e          state_q, state_nx;
  logic [CIDX_W-1:0]  col_q, col_nx;
  logic [RIDX_W-1:0]  row_q, row_nx, ref_q, ref_nx;
  logic               done_nx;
  logic               res_valid_nx;
  logic signed [DW-1:0] res_data_nx;

  logic [FRAC_W-1:0]    frac_tab [MAX_ROWS];
  logic signed [DW-1:0] prev_tab [MAX_ROWS];

  logic                 vec_fire, mat_fire, last_col, last_row, last_ref;
  logic                 fifo_push;
  logic [DW-1:0]        fifo_wdata, fifo_head;
  logic [LEN_W-1:0]     fifo_cnt;
  logic signed [ACC_W-1:0] init_val;
  logic signed [DW-1:0] row_result;

  // Operand FIFO: loaded from the stream, recirculated per row, refilled on reuse.
  mvmac_fifo #(.W(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .push_data(fifo_wdata),
    .pop(mat_fire), .head(fifo_head), .count(fifo_cnt)
  );

  mvmac_acc #(.DW(DW), .ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .en(mat_fire), .first(col_q == '0),
    .a(mat_data), .b(signed'(fifo_head)), .init(init_val),
    .frac(frac_tab[row_q]), .sat_out(row_result)
  );

  always_comb begin
    vec_ready = (state_q == ST_IDLE) && (fifo_cnt < cfg_row_len);
    mat_ready = (state_q == ST_RUN) && (fifo_cnt != '0) && !(res_valid && !res_ready);
    vec_fire  = vec_valid && vec_ready;
    mat_fire  = mat_valid && mat_ready;
    last_col  = LEN_W'(col_q) == (cfg_row_len - 1'b1);
    last_row  = ROW_W'(row_q) == (cfg_row_cnt - 1'b1);
    last_ref  = ROW_W'(ref_q) == (cfg_row_cnt - 1'b1);
    init_val  = cfg_acc_prev
              ? ({{(ACC_W-DW){prev_tab[row_q][DW-1]}}, prev_tab[row_q]} <<< frac_tab[row_q])
              : '0;
    busy      = (state_q != ST_IDLE);
  end

  // Operand FIFO write source per phase
  always_comb begin
    fifo_push  = 1'b0;
    fifo_wdata = vec_data;
    case (state_q)
      ST_IDLE:   fifo_push = vec_fire;
      ST_RUN: begin
        fifo_push  = mat_fire && !last_row;
        fifo_wdata = fifo_head;
      end
      ST_REFILL: begin
        fifo_push  = 1'b1;
        fifo_wdata = prev_tab[ref_q];
      end
      default: fifo_push = 1'b0;
    endcase
  end

  // Next-state logic
  always_comb begin
    state_nx     = state_q;
    col_nx       = col_q;
    row_nx       = row_q;
    ref_nx       = ref_q;
    done_nx      = 1'b0;
    res_valid_nx = res_valid && !res_ready;
    res_data_nx  = res_data;
    case (state_q)
      ST_IDLE: begin
        if (fifo_cnt == cfg_row_len && cfg_row_len != '0 && cfg_row_cnt != '0)
          state_nx = ST_RUN;
      end
      ST_RUN: begin
        if (mat_fire) begin
          if (last_col) begin
            col_nx       = '0;
            res_valid_nx = 1'b1;
            res_data_nx  = row_result;
            if (last_row) begin
              row_nx   = '0;
              state_nx = cfg_reuse ? ST_REFILL : ST_IDLE;
              done_nx  = !cfg_reuse;
            end else begin
              row_nx = row_q + 1'b1;
            end
          end else begin
            col_nx = col_q + 1'b1;
          end
        end
      end
      ST_REFILL: begin
        if (last_ref) begin
          ref_nx   = '0;
          state_nx = ST_IDLE;
          done_nx  = 1'b1;
        end else begin
          ref_nx = ref_q + 1'b1;
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      col_q     <= '0;
      row_q     <= '0;
      ref_q     <= '0;
      done      <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      state_q   <= state_nx;
      col_q     <= col_nx;
      row_q     <= row_nx;
      ref_q     <= ref_nx;
      done      <= done_nx;
      res_valid <= res_valid_nx;
      res_data  <= res_data_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (frac_we) frac_tab[frac_addr] <= frac_val;
    if (mat_fire && last_col) prev_tab[row_q] <= row_result;
  end

  // R4
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  // R1
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_ready && mat_ready));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/mvmac_stream_test.sv
`timescale 1ns/1ps
module mvmac_stream_test;
  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] cfg_row_len;
  logic [4:0] cfg_row_cnt;
  logic cfg_reuse, cfg_acc_prev, frac_we;
  logic [3:0] frac_addr, frac_val;
  logic vec_valid, vec_ready, mat_valid, mat_ready, res_valid, res_ready, busy, done;
  logic signed [15:0] vec_data, mat_data, res_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int done_cnt, done_cyc;
  bit done_busy;
  int ev [128];
  int mat [16][128];
  int frac_m [16];
  int prevm [16];
  int expv [16];

  mvmac_stream uut (
    .clk(clk), .rst_n(rst_n), .cfg_row_len(cfg_row_len), .cfg_row_cnt(cfg_row_cnt),
    .cfg_reuse(cfg_reuse), .cfg_acc_prev(cfg_acc_prev), .frac_we(frac_we),
    .frac_addr(frac_addr), .frac_val(frac_val), .vec_valid(vec_valid),
    .vec_ready(vec_ready), .vec_data(vec_data), .mat_valid(mat_valid),
    .mat_ready(mat_ready), .mat_data(mat_data), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .busy(busy), .done(done)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (done) begin
    done_cnt++; done_cyc = cyc; done_busy = busy;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint expct);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expct);
    end
  endtask

  function automatic int sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int model_row(input int r, input int len, input bit accp);
    longint s = 0;
    for (int j = 0; j < len; j++) s += longint'(mat[r][j]) * longint'(ev[j]);
    if (accp) s += longint'(prevm[r]) <<< frac_m[r];
    return sat16(s >>> frac_m[r]);
  endfunction

  function automatic int rnd(input int lo, input int hi);
    return int'($urandom_range(32'(hi - lo), 0)) + lo;
  endfunction

  task automatic set_frac(input int r, input int f);
    frac_m[r] = f;
    frac_we = 1'b1; frac_addr = 4'(r); frac_val = 4'(f);
    @(negedge clk);
    frac_we = 1'b0;
  endtask

  task automatic send_vec(input int d);
    vec_valid = 1'b1; vec_data = 16'(d);
    while (!vec_ready) @(negedge clk);
    @(negedge clk);
    vec_valid = 1'b0;
  endtask

  task automatic send_mat(input int d);
    mat_valid = 1'b1; mat_data = 16'(d);
    while (!mat_ready) @(negedge clk);
    @(negedge clk);
    mat_valid = 1'b0;
  endtask

  task automatic run_op(input int len, input int rows, input bit reuse, input bit accp,
                        input bit load, input string tag);
    int last_cyc;
    int k;
    logic signed [15:0] held;
    cfg_row_len = 8'(len); cfg_row_cnt = 5'(rows);
    cfg_reuse = reuse; cfg_acc_prev = accp;
    done_cnt = 0;
    if (load) begin
      @(negedge clk);
      // R1: idle and open for a vector
      check(!busy && vec_ready && !mat_ready, "R1", {busy, vec_ready, mat_ready}, 3'b010);
      for (int j = 0; j < len; j++) send_vec(ev[j]);
      // R1: full FIFO closes the vector stream
      check(!vec_ready, "R1", vec_ready, 0);
    end else begin
      @(negedge clk);
      // R7: chained start with no vector transfer
      check(busy && !vec_ready, "R7", {busy, vec_ready}, 2'b10);
    end
    for (int r = 0; r < rows; r++) expv[r] = model_row(r, len, accp);
    for (int r = 0; r < rows; r++) begin
      for (int j = 0; j < len; j++) send_mat(mat[r][j]);
      last_cyc = cyc;
      // R4: result due one cycle after the last element of the row
      check(res_valid == 1'b1, "R4", res_valid, 1);
      held = res_data;
      check(res_data == 16'(expv[r]), tag, res_data, expv[r]);
      if (reuse && r == rows - 1)
        // R7: copy phase blocks both input streams
        check(!mat_ready && !vec_ready, "R7", {mat_ready, vec_ready}, 0);
      else if (r != rows - 1)
        // R3: no vector reload between rows
        check(!vec_ready && busy, "R3", {vec_ready, busy}, 2'b01);
      k = rnd(0, 2);
      repeat (k) begin
        @(negedge clk);
        // R4: held while stalled, matrix stalled
        check(res_valid && res_data == held && !mat_ready, "R4", res_data, held);
      end
      res_ready = 1'b1;
      @(negedge clk);
      res_ready = 1'b0;
    end
    repeat (rows + 3) @(negedge clk);
    // R9: done pulse timing and busy low
    check(done_cnt == 1, "R9", done_cnt, 1);
    check(done_cyc == last_cyc + (reuse ? rows : 0) && !done_busy, "R9",
          done_cyc, last_cyc + (reuse ? rows : 0));
    for (int r = 0; r < rows; r++) begin
      prevm[r] = expv[r];
      if (reuse) ev[r] = expv[r];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    cfg_row_len = 8'd4; cfg_row_cnt = 5'd1; cfg_reuse = 1'b0; cfg_acc_prev = 1'b0;
    frac_we = 1'b0; frac_addr = '0; frac_val = '0;
    vec_valid = 1'b0; vec_data = '0; mat_valid = 1'b0; mat_data = '0; res_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(!busy && !done && !res_valid && !mat_ready && vec_ready, "R10",
          {busy, done, res_valid, mat_ready, vec_ready}, 5'b00001);
    for (int r = 0; r < 16; r++) set_frac(r, 0);

    // R2: small directed product
    ev[0] = 1; ev[1] = 2; ev[2] = -3; ev[3] = 4;
    for (int r = 0; r < 3; r++) for (int j = 0; j < 4; j++) mat[r][j] = (r + 1) * (j - 1);
    run_op(4, 3, 1'b0, 1'b0, 1'b1, "R2");

    // R5: saturation at both rails
    ev[0] = 32767; ev[1] = 32767;
    mat[0][0] = 32767;  mat[0][1] = 32767;
    mat[1][0] = -32768; mat[1][1] = -32768;
    run_op(2, 2, 1'b0, 1'b0, 1'b1, "R5");

    // R6: per-position shifts, rounding toward minus infinity
    set_frac(0, 1); set_frac(1, 2); set_frac(2, 0);
    ev[0] = 3; ev[1] = 5; ev[2] = -7;
    mat[0][0] = 1; mat[0][1] = 1; mat[0][2] = 1;
    mat[1][0] = 1; mat[1][1] = 0; mat[1][2] = 1;
    mat[2][0] = 2; mat[2][1] = 2; mat[2][2] = 2;
    run_op(3, 3, 1'b0, 1'b0, 1'b1, "R6");

    // R1: longest row
    set_frac(0, 9); set_frac(1, 15);
    for (int j = 0; j < 128; j++) begin
      ev[j] = rnd(-32768, 32767); mat[0][j] = rnd(-32768, 32767); mat[1][j] = rnd(-32768, 32767);
    end
    run_op(128, 2, 1'b0, 1'b0, 1'b1, "R1");

    // R2: random operations
    for (int t = 0; t < 6; t++) begin
      int len = rnd(1, 40);
      int rows = rnd(1, 16);
      int mag = (t % 2 == 0) ? 200 : 32767;
      for (int r = 0; r < rows; r++) set_frac(r, rnd(0, 15));
      for (int j = 0; j < len; j++) ev[j] = rnd(-mag, mag);
      for (int r = 0; r < rows; r++) for (int j = 0; j < len; j++) mat[r][j] = rnd(-mag, mag);
      run_op(len, rows, 1'b0, 1'b0, 1'b1, "R2");
    end

    // R7: chained operations through the result copy
    for (int r = 0; r < 16; r++) set_frac(r, rnd(0, 6));
    for (int j = 0; j < 12; j++) ev[j] = rnd(-300, 300);
    for (int r = 0; r < 8; r++) for (int j = 0; j < 12; j++) mat[r][j] = rnd(-300, 300);
    run_op(12, 8, 1'b1, 1'b0, 1'b1, "R7");
    for (int r = 0; r < 5; r++) for (int j = 0; j < 8; j++) mat[r][j] = rnd(-300, 300);
    run_op(8, 5, 1'b0, 1'b0, 1'b0, "R7");

    // R8: add onto the previous results
    for (int j = 0; j < 6; j++) ev[j] = rnd(-300, 300);
    for (int r = 0; r < 5; r++) for (int j = 0; j < 6; j++) mat[r][j] = rnd(-300, 300);
    run_op(6, 5, 1'b0, 1'b1, 1'b1, "R8");
    for (int j = 0; j < 6; j++) ev[j] = rnd(-32767, 32767);
    for (int r = 0; r < 5; r++) for (int j = 0; j < 6; j++) mat[r][j] = rnd(-32767, 32767);
    run_op(6, 5, 1'b0, 1'b1, 1'b1, "R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule